// File: doc/BRIEF.md
# Microcontroller Interrupt Flag Controller

This block collects three interrupt sources for a small 8-bit microcontroller core and turns them into a single vector request and a wake-up signal. The three sources are an edge-triggered external pin, an overflow strobe from an 8-bit timer, and a change detector on a 4-bit slice of an input port. Each source owns a sticky flag and an enable bit. A global enable gates the request to the core. Taking the interrupt clears the global enable, and a return-from-interrupt pulse sets it again. The handler saves any context it needs in firmware; the core itself pushes only the return address.

While the core sleeps, any source whose flag and enable are both set raises `wake`, whatever the global enable holds. After waking, the global enable alone decides whether the core also vectors. The external pin passes through a synchronizer, and its active edge is chosen by a polarity bit. The port slice is synchronized and compared against a copy that is taken on every port read. Any mismatch keeps the change flag set.

Software reaches the flags, the enables, the global enable and the polarity bit through a one-cycle register write strobe and a combinational read mux. Every interface here is a plain control strobe or level. No data stream passes through the block, so it has no valid/ready back-pressure.

Top module: `intr_flag_ctrl`

## Requirements
- R1: After reset, all flags, all enables, the global enable and the polarity bit are 0, and `irq_req` and `wake` are 0. With `reg_sel`=0 the read data is {bit7 global enable, bit6 port-change enable, bit5 timer enable, bit4 external enable, bit3 reads 0, bit2 port-change flag, bit1 timer flag, bit0 external flag}. With `reg_sel`=1 bit0 is the polarity bit and the other bits read 0.
- R2: With polarity 1 a rising edge on `ext_pin` sets the external flag, and with polarity 0 a falling edge sets it. The edge of the other direction has no effect. The flag becomes visible after the third rising clock edge following the pin change, and is still 0 after the second.
- R3: A flag stays set until a control write (`reg_wr`=1, `reg_sel`=0) puts 0 in its bit. Writing 1 to a flag bit sets it.
- R4: If a control write clears a flag in the same cycle as a new event for that source, the flag stays set.
- R5: A one-cycle `tmr_ovf` pulse sets the timer flag at the next clock edge.
- R6: The synchronized `port_hi` is compared every cycle with a copy that is loaded on each `port_rd` pulse, and the copy resets to 0. Any mismatch sets the port-change flag after the third clock edge following a pin change. After a `port_rd`, a cleared flag stays clear.
- R7: `irq_req` is 1 exactly when the global enable is 1 and at least one source has both its flag and its enable set. A set flag whose enable is 0 produces no request.
- R8: `irq_ack` clears the global enable at the next clock edge, so `irq_req` falls. `irq_ack` wins over `reti` and over a register write in the same cycle.
- R9: A `reti` pulse without `irq_ack` sets the global enable at the next clock edge.
- R10: `wake` is 1 exactly when `sleeping` is 1 and some source has both its flag and its enable set, whatever the global enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| tmr_ovf | input | 1 | One-cycle strobe when the timer rolls from FFh to 00h |
| port_hi | input | 4 | Upper port bits watched for change (asynchronous) |
| port_rd | input | 1 | Port read strobe; loads the comparison copy |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the option register |
| reg_wdata | input | 8 | Register write data |
| reg_rd_data | output | 8 | Read data of the selected register |
| sleeping | input | 1 | Core is in sleep |
| irq_ack | input | 1 | Core takes the interrupt vector |
| reti | input | 1 | Core returns from the interrupt |
| irq_req | output | 1 | Vector request to the core |
| wake | output | 1 | Wake-up request while sleeping |

## Verification
The assertions check every cycle that a timer strobe lands in its flag, that flags never drop without a control write, that an acknowledge takes down both the global enable and the request, that a return sets the global enable, and that neither `wake` nor `irq_req` is raised without sleep or the global enable. Only the bench scenarios can show the edge-polarity choice and the three-edge synchronizer latency. The same holds for the port-read copy semantics, the event-over-clear collision, and wake-up with the global enable clear.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_CHG = 2;
  localparam int EN_LSB  = 4;
  localparam int GIE_BIT = 7;
  localparam int POL_BIT = 0;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_OPT = 1'b1} reg_sel_e;
endpackage

// File: rtl/ifc_sync.sv
module ifc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ifc_edge.sv
module ifc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  input  logic pol,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= s;
  end

  // pol=1 -> rising, pol=0 -> falling
  assign hit = pol ? (s & ~prev) : (~s & prev);
endmodule

// File: rtl/ifc_chg.sv
module ifc_chg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s,
  input  logic         snap,
  output logic         hit
);
  logic [W-1:0] copy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    copy_q <= '0;
    else if (snap) copy_q <= s;
  end

  assign hit = |(s ^ copy_q);
endmodule

// File: rtl/ifc_flag.sv
module ifc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  // a hardware event outranks a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_evt) q <= 1'b1;
    else if (wr_en)   q <= wr_val;
  end
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl
  import ifc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              port_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              sleeping,
  input  logic              irq_ack,
  input  logic              reti,
  output logic              irq_req,
  output logic              wake
);
  logic              ext_s, ext_hit, chg_hit;
  logic [PORT_W-1:0] port_s;
  logic [NSRC-1:0]   evt, flag_q, en_q, pend;
  logic              glob_en, pol_q, wr_ctrl, wr_opt;

  ifc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s));

  ifc_edge u_ext_edge (
    .clk(clk), .rst_n(rst_n), .s(ext_s), .pol(pol_q), .hit(ext_hit));

  ifc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d(port_hi), .q(port_s));

  ifc_chg #(.W(PORT_W)) u_chg (
    .clk(clk), .rst_n(rst_n), .s(port_s), .snap(port_rd), .hit(chg_hit));

  assign evt[SRC_EXT] = ext_hit;
  assign evt[SRC_TMR] = tmr_ovf;
  assign evt[SRC_CHG] = chg_hit;

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_opt  = reg_wr && (reg_sel == SEL_OPT);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ifc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_evt(evt[g]),
      .wr_en(wr_ctrl), .wr_val(reg_wdata[g]), .q(flag_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q  <= reg_wdata[EN_LSB +: NSRC];
      if (wr_opt)  pol_q <= reg_wdata[POL_BIT];
    end
  end

  // acknowledge > return > software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glob_en <= 1'b0;
    else if (irq_ack) glob_en <= 1'b0;
    else if (reti)    glob_en <= 1'b1;
    else if (wr_ctrl) glob_en <= reg_wdata[GIE_BIT];
  end

  assign pend    = flag_q & en_q;
  assign irq_req = glob_en & (|pend);
  assign wake    = sleeping & (|pend);

  always_comb begin
    reg_rd_data = '0;
    if (reg_sel == SEL_CTRL) begin
      reg_rd_data[NSRC-1:0]          = flag_q;
      reg_rd_data[EN_LSB +: NSRC]    = en_q;
      reg_rd_data[GIE_BIT]           = glob_en;
    end else begin
      reg_rd_data[POL_BIT]           = pol_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_ovf,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic       irq_ack,
  input logic       reti,
  input logic       irq_req,
  input logic       wake,
  input logic       sleeping,
  input logic       glob_en,
  input logic [2:0] flag_q
);
  a_r5_tmr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flag_q[1]);

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_sel) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r8_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_req && !glob_en));

  a_r9_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> glob_en);

  a_r7_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_en);

  a_r10_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleeping);
endmodule

bind intr_flag_ctrl ifc_checker u_ifc_checker (
  .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req),
  .wake(wake), .sleeping(sleeping), .glob_en(glob_en), .flag_q(flag_q));

// File: tb/test_intr_flag_ctrl.sv
module test_intr_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, tmr_ovf = 1'b0, port_rd = 1'b0;
  logic [3:0] port_hi = 4'h0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rd_data;
  logic       sleeping = 1'b0, irq_ack = 1'b0, reti = 1'b0;
  logic       irq_req, wake;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  intr_flag_ctrl i_intr_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_hi(port_hi), .port_rd(port_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .sleeping(sleeping),
    .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .wake(wake));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    #1;
    v = reg_rd_data;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    rd(1'b1, v); chk("R1 opt", v, 8'h00);
    chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr(1'b1, 8'h01);
    ext_pin = 1'b1; step(2);
    rd(1'b0, v); chk("R2 rising not yet", v, 8'h00);
    step(1);
    rd(1'b0, v); chk("R2 rising flag", v, 8'h01);
    chk("R7 ext flag without enable", {7'd0, irq_req}, 8'h00);
    wr(1'b0, 8'h00);
    ext_pin = 1'b0; step(4);
    rd(1'b0, v); chk("R2 falling ignored pol1", v, 8'h00);
    wr(1'b1, 8'h00);
    ext_pin = 1'b1; step(4);
    rd(1'b0, v); chk("R2 rising ignored pol0", v, 8'h00);
    ext_pin = 1'b0; step(2);
    rd(1'b0, v); chk("R2 falling not yet", v, 8'h00);
    step(1);
    rd(1'b0, v); chk("R2 falling flag", v, 8'h01);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_tmr();
    logic [7:0] v;
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    rd(1'b0, v); chk("R5 timer flag", v, 8'h02);
    step(5);
    rd(1'b0, v); chk("R3 flag sticky", v, 8'h02);
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R3 write clears", v, 8'h00);
    wr(1'b0, 8'h04);
    rd(1'b0, v); chk("R3 write sets", v, 8'h04);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(1'b0, 8'h02);
    reg_sel = 1'b0; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf = 1'b1;
    step(1);
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    rd(1'b0, v); chk("R4 event beats clear", v, 8'h02);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_port();
    logic [7:0] v;
    port_hi = 4'b0100; step(2);
    rd(1'b0, v); chk("R6 change not yet", v, 8'h00);
    step(1);
    rd(1'b0, v); chk("R6 change flag", v, 8'h04);
    port_rd = 1'b1; step(1); port_rd = 1'b0;
    wr(1'b0, 8'h00); step(3);
    rd(1'b0, v); chk("R6 cleared after read", v, 8'h00);
    port_hi = 4'b0000; step(3);
    rd(1'b0, v); chk("R6 change back vs copy", v, 8'h04);
    port_rd = 1'b1; step(1); port_rd = 1'b0;
    wr(1'b0, 8'h00); step(2);
    rd(1'b0, v); chk("R6 stays clear", v, 8'h00);
  endtask

  task automatic t_req();
    logic [7:0] v;
    wr(1'b0, 8'hA0);
    chk("R7 no flag no req", {7'd0, irq_req}, 8'h00);
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
    chk("R7 req raised", {7'd0, irq_req}, 8'h01);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    chk("R8 ack drops req", {7'd0, irq_req}, 8'h00);
    rd(1'b0, v); chk("R8 gie cleared", v, 8'h22);
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R9 reti re-raises req", {7'd0, irq_req}, 8'h01);
    rd(1'b0, v); chk("R9 gie set", v, 8'hA2);
    irq_ack = 1'b1; reti = 1'b1; step(1); irq_ack = 1'b0; reti = 1'b0;
    rd(1'b0, v); chk("R8 ack beats reti", v, 8'h22);
    wr(1'b0, 8'h82);
    chk("R7 disabled flag no req", {7'd0, irq_req}, 8'h00);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_wake();
    wr(1'b0, 8'h22);
    sleeping = 1'b1; #1;
    chk("R10 wake without gie", {7'd0, wake}, 8'h01);
    chk("R10 no vector without gie", {7'd0, irq_req}, 8'h00);
    sleeping = 1'b0; #1;
    chk("R10 no wake awake", {7'd0, wake}, 8'h00);
    wr(1'b0, 8'h02);
    sleeping = 1'b1; #1;
    chk("R10 no wake when disabled", {7'd0, wake}, 8'h00);
    sleeping = 1'b0;
    step(1);
    wr(1'b0, 8'h00);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_ext();
    t_tmr();
    t_collide();
    t_port();
    t_req();
    t_wake();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule